// File: doc/BRIEF.md
# Registered 12x12 Multiplier with Format Adjust

This block multiplies two 12-bit operands and returns the upper sixteen bits of the 24-bit product. Each operand has its own input register with its own clock, so two independent sources can present data at their own pace. A mode bit, sampled on the same edge as the second operand, picks the arithmetic. When high, both operands are read as two's complement. When low, both are read as unsigned magnitude. No mixed mode exists.

In two's complement mode the product is shifted up one place before it is cut to sixteen bits. This drops the redundant sign copy and gains one bit of precision. In unsigned mode the top sixteen bits are taken as they are. The adjusted value is loaded into a result register on the operand-B clock. The result reaches the pins only while the output enable is high; otherwise the pins float. An active-low reset clears every register asynchronously. Its release is synchronized separately into each clock domain.

Top module: `regmul12_fmt`

## Requirements
- R1: Operand A is loaded only on a rising edge of `clk_a`; while `clk_a` has no edge, a changed `opa_i` has no effect on later results.
- R2: Operand B and the mode bit `twos_i` are loaded together on a rising edge of `clk_b`.
- R3: Mode value 1 treats both operands as two's complement; mode value 0 treats both as unsigned magnitude.
- R4: In two's complement mode the result equals bits [22:7] of the 24-bit signed product; for example, -2048 x 2047 gives 16'h8010.
- R5: In unsigned mode the result equals bits [23:8] of the 24-bit unsigned product; for example, 4095 x 4095 gives 16'hFFE0.
- R6: Bits below the kept field are discarded without rounding; for example, unsigned 1 x 255 gives 0, and signed -1 x 1 gives 16'hFFFF.
- R7: On a `clk_b` edge the result register captures the product of the register contents held before that edge. A new operand pair therefore appears on the second `clk_b` edge after it is presented.
- R8: With `oe_i` high, `res_o` shows the result register; with `oe_i` low, every bit of `res_o` is high impedance.
- R9: `rst_n` low clears the operand, mode and result registers to zero at once, without waiting for a clock edge.
- R10: Signed -2048 x -2048 wraps to 16'h8000, and any zero operand gives a result of 0 in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock for the operand-A register |
| clk_b | input | 1 | Clock for the operand-B, mode and result registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa_i | input | 12 | Operand A |
| opb_i | input | 12 | Operand B |
| twos_i | input | 1 | Mode: 1 two's complement, 0 unsigned |
| oe_i | input | 1 | Output enable, active high |
| res_o | output | 16 | Adjusted product, high impedance when disabled |

## Verification
A wrong mode latch or a wrong slice choice changes the result on the second `clk_b` edge after the operands are presented. The sign-boundary operands make the one-bit offset between the two slices visible in the top result bit. A register that takes data on the wrong clock shows up when `clk_a` is held still. The result then moves with `opa_i` when it should keep the old product. A result register fed from post-edge values shows the new product one edge early. The pipeline test catches this on the first edge.

// File: rtl/regmul_pkg.sv
package regmul_pkg;
  typedef enum logic {
    MODE_UNSIGNED = 1'b0,
    MODE_TWOS     = 1'b1
  } mul_mode_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/regmul_rst_sync.sv
module regmul_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/regmul_opreg.sv
module regmul_opreg #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;
  logic [W-1:0] q_q;

  always_comb begin
    q_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  // R1 (A instance) and R2 (B instance): register follows its input one edge later
  p_reg_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (q_o == $past(d_i)));
endmodule

// File: rtl/regmul_fmt_adjust.sv
module regmul_fmt_adjust
  import regmul_pkg::*;
#(
  parameter int unsigned OP_W  = 12,
  parameter int unsigned RES_W = 16
) (
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  input  mul_mode_e         mode_i,
  output logic [2*OP_W-1:0] prod_o,
  output logic [RES_W-1:0]  res_o
);
  localparam int unsigned PROD_W = 2 * OP_W;

  logic [PROD_W-1:0] ext_a;
  logic [PROD_W-1:0] ext_b;
  logic [PROD_W-1:0] prod;

  // One multiplier serves both modes: sign or zero extension to full width
  always_comb begin
    if (mode_i == MODE_TWOS) begin
      ext_a = {{OP_W{a_i[OP_W-1]}}, a_i};
      ext_b = {{OP_W{b_i[OP_W-1]}}, b_i};
    end else begin
      ext_a = {{OP_W{1'b0}}, a_i};
      ext_b = {{OP_W{1'b0}}, b_i};
    end
    prod = ext_a * ext_b;
  end

  // Format adjust: signed drops the duplicate sign bit, unsigned keeps the top
  always_comb begin
    if (mode_i == MODE_TWOS) res_o = prod[PROD_W-2 -: RES_W];
    else                     res_o = prod[PROD_W-1 -: RES_W];
  end

  assign prod_o = prod;
endmodule

// File: rtl/regmul12_fmt.sv
module regmul12_fmt
  import regmul_pkg::*;
#(
  parameter int unsigned OP_W  = 12,
  parameter int unsigned RES_W = 16
) (
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  opa_i,
  input  logic [OP_W-1:0]  opb_i,
  input  logic             twos_i,
  input  logic             oe_i,
  output logic [RES_W-1:0] res_o
);
  localparam int unsigned PROD_W = 2 * OP_W;
  localparam logic [OP_W-1:0] MOST_NEG = {1'b1, {(OP_W-1){1'b0}}};

  logic rst_a_n;
  logic rst_b_n;

  regmul_rst_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
    .clk(clk_a), .rst_n(rst_n), .rst_sync_n(rst_a_n));
  regmul_rst_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
    .clk(clk_b), .rst_n(rst_n), .rst_sync_n(rst_b_n));

  logic [OP_W-1:0] a_q;
  logic [OP_W:0]   bm_q;
  logic [OP_W-1:0] b_q;
  mul_mode_e       mode_q;

  regmul_opreg #(.W(OP_W)) u_reg_a (
    .clk(clk_a), .rst_n(rst_a_n), .d_i(opa_i), .q_o(a_q));

  // Mode bit travels in the same register as operand B
  regmul_opreg #(.W(OP_W+1)) u_reg_b (
    .clk(clk_b), .rst_n(rst_b_n), .d_i({twos_i, opb_i}), .q_o(bm_q));

  assign b_q    = bm_q[OP_W-1:0];
  assign mode_q = mul_mode_e'(bm_q[OP_W]);

  logic [PROD_W-1:0] prod_w;
  logic [RES_W-1:0]  adj_w;

  regmul_fmt_adjust #(.OP_W(OP_W), .RES_W(RES_W)) u_fmt (
    .a_i(a_q), .b_i(b_q), .mode_i(mode_q), .prod_o(prod_w), .res_o(adj_w));

  logic [RES_W-1:0] res_d;
  logic [RES_W-1:0] res_q;

  always_comb begin
    res_d = adj_w;
  end

  always_ff @(posedge clk_b or negedge rst_b_n) begin
    if (!rst_b_n) res_q <= '0;
    else          res_q <= res_d;
  end

  assign res_o = oe_i ? res_q : {RES_W{1'bz}};

  // R7: result holds the adjusted product seen just before the edge
  p_res_capture_r7: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    1'b1 |=> (res_q == $past(adj_w)));

  // R4: signed product carries a duplicate sign bit except for most-negative squared
  p_sign_dup_r4: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (mode_q == MODE_TWOS && !(a_q == MOST_NEG && b_q == MOST_NEG))
      |-> (prod_w[PROD_W-1] == prod_w[PROD_W-2]));

  // R5: unsigned multiply by one returns operand A unchanged
  p_uns_identity_r5: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (mode_q == MODE_UNSIGNED && b_q == OP_W'(1))
      |-> (prod_w == {{OP_W{1'b0}}, a_q}));

  // R3: signed multiply by zero yields zero regardless of A
  p_zero_r3: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (b_q == '0) |-> (prod_w == '0));

  // R9: result register leaves reset cleared
  p_reset_clear_r9: assert property (@(posedge clk_b)
    $rose(rst_b_n) |-> (res_q == '0));
endmodule

// File: tb/regmul12_fmt_tb.sv
module regmul12_fmt_tb;
  logic        clk;
  logic        en_a, en_b;
  logic        clk_a, clk_b;
  logic        rst_n;
  logic [11:0] opa, opb;
  logic        twos;
  logic        oe;
  wire  [15:0] res;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  assign clk_a = clk & en_a;
  assign clk_b = clk & en_b;

  regmul12_fmt u_dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .opa_i(opa), .opb_i(opb), .twos_i(twos), .oe_i(oe), .res_o(res));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] model(logic [11:0] a, logic [11:0] b, logic m);
    logic [23:0] ea, eb, p;
    ea = m ? {{12{a[11]}}, a} : {12'd0, a};
    eb = m ? {{12{b[11]}}, b} : {12'd0, b};
    p  = ea * eb;
    return m ? p[22:7] : p[23:8];
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_mul(logic [11:0] a, logic [11:0] b, logic m);
    @(negedge clk);
    opa = a; opb = b; twos = m; en_a = 1'b1; en_b = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R9 reset", res, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R9 after release", res, 16'h0000);
  endtask

  task automatic t_signed();
    do_mul(12'd3, 12'hFFB, 1'b1);
    chk("R3 R4 signed 3*-5", res, model(12'd3, 12'hFFB, 1'b1));
    do_mul(12'h7FF, 12'h7FF, 1'b1);
    chk("R4 signed max*max", res, model(12'h7FF, 12'h7FF, 1'b1));
    do_mul(12'h800, 12'h7FF, 1'b1);
    chk("R4 -2048*2047", res, 16'h8010);
  endtask

  task automatic t_unsigned();
    do_mul(12'hFFF, 12'hFFF, 1'b0);
    chk("R5 4095*4095", res, 16'hFFE0);
    do_mul(12'hFFB, 12'd3, 1'b0);
    chk("R3 R5 unsigned 4091*3", res, model(12'hFFB, 12'd3, 1'b0));
    do_mul(12'h800, 12'h800, 1'b0);
    chk("R5 unsigned 2048*2048", res, 16'h4000);
  endtask

  task automatic t_trunc();
    do_mul(12'd1, 12'd255, 1'b0);
    chk("R6 unsigned 1*255", res, 16'h0000);
    do_mul(12'hFFF, 12'd1, 1'b1);
    chk("R6 signed -1*1", res, 16'hFFFF);
  endtask

  task automatic t_corners();
    do_mul(12'h800, 12'h800, 1'b1);
    chk("R10 -2048*-2048", res, 16'h8000);
    do_mul(12'd0, 12'hABC, 1'b1);
    chk("R10 zero A signed", res, 16'h0000);
    do_mul(12'hFFF, 12'd0, 1'b0);
    chk("R10 zero B unsigned", res, 16'h0000);
  endtask

  task automatic t_hold_a();
    do_mul(12'd100, 12'd200, 1'b0);
    @(negedge clk);
    en_a = 1'b0; opa = 12'd777; opb = 12'd3000;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R1 A held without clk_a", res, model(12'd100, 12'd3000, 1'b0));
    en_a = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R1 A loads on clk_a", res, model(12'd777, 12'd3000, 1'b0));
  endtask

  task automatic t_pipeline();
    do_mul(12'h123, 12'h456, 1'b0);
    @(negedge clk);
    opa = 12'hF00; opb = 12'h0F0; twos = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R7 first edge keeps old product", res, model(12'h123, 12'h456, 1'b0));
    @(posedge clk); @(negedge clk);
    chk("R2 R7 second edge new product", res, model(12'hF00, 12'h0F0, 1'b1));
  endtask

  task automatic t_oe();
    do_mul(12'h555, 12'h0AA, 1'b0);
    oe = 1'b0; #1;
    chk("R8 disabled is z", res, 16'hzzzz);
    oe = 1'b1; #1;
    chk("R8 enabled drives", res, model(12'h555, 12'h0AA, 1'b0));
  endtask

  task automatic t_async_reset();
    do_mul(12'h7AB, 12'h321, 1'b1);
    #0.5 rst_n = 1'b0; #0.5;
    chk("R9 async clear", res, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    rst_n = 1'b0; en_a = 1'b1; en_b = 1'b1;
    opa = '0; opb = '0; twos = 1'b0; oe = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_signed();
    t_unsigned();
    t_trunc();
    t_corners();
    t_hold_a();
    t_pipeline();
    t_oe();
    t_async_reset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule